// File: doc/BRIEF.md
# RISC Integer Execute Unit with Barrel Shifter

This block is the integer execute stage of a three-operand load/store RISC core. It is purely combinational. It takes two 32-bit register operands, a 16-bit immediate field, a 5-bit constant shift amount and a 5-bit operation code. From these it returns a 32-bit result, a signed-overflow exception flag and a qualified register write enable. The unit covers:

- add and subtract, in trapping and wrapping forms;
- the four bitwise logic functions;
- shifts left, right logical and right arithmetic, by a constant or by a register amount;
- signed and unsigned less-than tests;
- loading of the upper half of a word.

When the immediate select is set, the immediate replaces the second operand. It is sign-extended for arithmetic and compare operations and zero-extended for logic operations. Instruction decode, the register file and the exception vectoring stay in the surrounding pipeline. That pipeline presents a decoded operation code and a write request, and stores the result only when the qualified write enable is high.

Top module: `rv_exec_alu`

## Requirements
- R1: Codes ADD=0, ADDU=1, SUB=2 and SUBU=3 give `opa + opb` or `opa - opb` modulo 2^32, where `opa` is `a_i` and `opb` is `b_i`, or the extended immediate when `use_imm_i`=1.
- R2: `ovf_o` is 1 only for ADD or SUB when the signed result does not fit in 32 bits. ADDU and SUBU never raise it.
- R3: `wr_en_o` equals `wr_req_i` AND NOT `ovf_o`, so a trapping overflow suppresses the destination write.
- R4: Codes AND=4, OR=5, XOR=6 and NOR=7 give the bitwise AND, OR, XOR and NOR of `opa` and `opb`.
- R5: Codes SLL=8, SRL=9 and SRA=10 shift `b_i` by `shamt_i`. SLL is left, SRL is right with zero fill, and SRA is right with the sign-bit fill.
- R6: Codes SLLV=11, SRLV=12 and SRAV=13 shift `b_i` by `a_i[4:0]`. Bits 31:5 of `a_i` have no effect.
- R7: Arithmetic right shifts replicate bit 31 of the shifted value into every vacated position.
- R8: SLT=14 returns 1 when `opa < opb` as signed numbers, and 0 otherwise. SLTU=15 does the same as unsigned numbers.
- R9: With `use_imm_i`=1, `imm_i` is sign-extended for codes 0-3, 14 and 15, including the unsigned compare. It is zero-extended for codes 4-7.
- R10: LUI=16 returns `{imm_i, 16'h0000}` whatever the value of `use_imm_i`.
- R11: Codes 17-31 return 0, with `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand; also the variable shift amount |
| b_i | input | 32 | Second register operand; the value being shifted |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | Replace the second operand with the extended immediate |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code |
| wr_req_i | input | 1 | Destination write request from decode |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed-overflow exception for trapping add and subtract |
| wr_en_o | output | 1 | Write enable, qualified by the overflow exception |

## Verification
Two functions share one evaluation: overflow detection on a trapping add or subtract, and qualification of the destination write. The bench provokes both together. It applies boundary operands such as 0x7FFFFFFF+1 and 0x80000000-1 with a write request high. It then checks three things: the wrapped result, the raised exception and the dropped write enable. The same operands under the wrapping codes must give an identical result with the write kept. The signed and unsigned compares both use the shared subtractor, so the bench gives them identical bit patterns and checks that their answers differ.

// File: rtl/rv_exec_pkg.sv
package rv_exec_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7,
    OP_SLL  = 5'd8,  OP_SRL  = 5'd9,  OP_SRA  = 5'd10,
    OP_SLLV = 5'd11, OP_SRLV = 5'd12, OP_SRAV = 5'd13,
    OP_SLT  = 5'd14, OP_SLTU = 5'd15, OP_LUI  = 5'd16
  } exec_op_e;
endpackage

// File: rtl/rv_exec_immext.sv
module rv_exec_immext #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic [IW-1:0] imm_i,
  input  logic          zext_i,
  output logic [W-1:0]  ext_o
);
  localparam int PADW = W - IW;
  logic fill;
  assign fill  = ~zext_i & imm_i[IW-1];
  assign ext_o = {{PADW{fill}}, imm_i};
endmodule

// File: rtl/rv_exec_addsub.sv
module rv_exec_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] bx;
  logic         cout;
  logic [W:0]   wide;

  always_comb begin
    bx            = sub_i ? ~b_i : b_i;
    {cout, sum_o} = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
    ovf_o         = (a_i[W-1] == bx[W-1]) & (sum_o[W-1] != a_i[W-1]);
    lt_s_o        = sum_o[W-1] ^ ovf_o;
    lt_u_o        = ~cout;
    // reference: sign-extended arithmetic one bit wider
    wide = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                 : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
    AST_OVF_WIDE: assert (ovf_o == (wide[W] != wide[W-1]))
      else $error("overflow flag disagrees with wide sum"); // R2
    AST_LTU_CMP: assert (!sub_i || (lt_u_o == (a_i < b_i)))
      else $error("unsigned less-than wrong"); // R8
    AST_LTS_CMP: assert (!sub_i || (lt_s_o == ($signed(a_i) < $signed(b_i))))
      else $error("signed less-than wrong"); // R8
  end
endmodule

// File: rtl/rv_exec_logic.sv
module rv_exec_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o,
  output logic [W-1:0] nor_o
);
  always_comb begin
    and_o = a_i & b_i;
    or_o  = a_i | b_i;
    xor_o = a_i ^ b_i;
    nor_o = ~or_o;
    AST_XOR_SPLIT: assert (xor_o == (or_o & ~and_o))
      else $error("xor not consistent with and/or"); // R4
  end
endmodule

// File: rtl/rv_exec_shift.sv
module rv_exec_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  res_o
);
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic [W-1:0] stg [SW+1];
  logic         fill;

  assign fill = arith_i & ~left_i & val_i[W-1];

  // left shift = bit-reverse, right shift, bit-reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = val_i[W-1-i];
    assign rev_out[i] = stg[SW][W-1-i];
  end

  assign stg[0] = left_i ? rev_in : val_i;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{SH{fill}}, stg[s][W-1:SH]} : stg[s];
  end

  assign res_o = left_i ? rev_out : stg[SW];
endmodule

// File: rtl/rv_exec_alu.sv
module rv_exec_alu #(
  parameter int W  = 32,
  parameter int IW = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          use_imm_i,
  input  logic [SW-1:0] shamt_i,
  input  logic [4:0]    op_i,
  input  logic          wr_req_i,
  output logic [W-1:0]  result_o,
  output logic          ovf_o,
  output logic          wr_en_o
);
  import rv_exec_pkg::*;

  localparam int LOW = W - IW;

  exec_op_e     op;
  logic         zext, sub, sh_left, sh_arith, sh_var, trap;
  logic [W-1:0] imm_ext, opb;
  logic [W-1:0] sum, and_r, or_r, xor_r, nor_r, sh_r;
  logic         ovf_raw, lt_s, lt_u;
  logic [SW-1:0] sh_amt;

  assign op       = exec_op_e'(op_i);
  assign zext     = (op == OP_AND) | (op == OP_OR) | (op == OP_XOR) | (op == OP_NOR);
  assign sub      = (op == OP_SUB) | (op == OP_SUBU) | (op == OP_SLT) | (op == OP_SLTU);
  assign sh_left  = (op == OP_SLL) | (op == OP_SLLV);
  assign sh_arith = (op == OP_SRA) | (op == OP_SRAV);
  assign sh_var   = (op == OP_SLLV) | (op == OP_SRLV) | (op == OP_SRAV);
  assign sh_amt   = sh_var ? a_i[SW-1:0] : shamt_i;
  assign opb      = use_imm_i ? imm_ext : b_i;

  rv_exec_immext #(.W(W), .IW(IW)) u_immext (
    .imm_i (imm_i), .zext_i (zext), .ext_o (imm_ext)
  );

  rv_exec_addsub #(.W(W)) u_addsub (
    .a_i (a_i), .b_i (opb), .sub_i (sub),
    .sum_o (sum), .ovf_o (ovf_raw), .lt_s_o (lt_s), .lt_u_o (lt_u)
  );

  rv_exec_logic #(.W(W)) u_logic (
    .a_i (a_i), .b_i (opb),
    .and_o (and_r), .or_o (or_r), .xor_o (xor_r), .nor_o (nor_r)
  );

  rv_exec_shift #(.W(W), .SW(SW)) u_shift (
    .val_i (b_i), .amt_i (sh_amt), .left_i (sh_left),
    .arith_i (sh_arith), .res_o (sh_r)
  );

  always_comb begin
    trap = 1'b0;
    case (op)
      OP_ADD, OP_SUB:   begin result_o = sum; trap = 1'b1; end
      OP_ADDU, OP_SUBU: result_o = sum;
      OP_AND:           result_o = and_r;
      OP_OR:            result_o = or_r;
      OP_XOR:           result_o = xor_r;
      OP_NOR:           result_o = nor_r;
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV: result_o = sh_r;
      OP_SLT:           result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:          result_o = {{(W-1){1'b0}}, lt_u};
      OP_LUI:           result_o = {imm_i, {LOW{1'b0}}};
      default:          result_o = '0;
    endcase
    ovf_o   = trap & ovf_raw;
    wr_en_o = wr_req_i & ~ovf_o;

    AST_TRAP_BLOCKS_WRITE: assert (!(trap && ovf_raw) || !wr_en_o)
      else $error("write not suppressed on overflow"); // R3
    AST_WRAP_NO_EXC: assert (!((op_i == 5'd1) || (op_i == 5'd3)) || !ovf_o)
      else $error("wrapping op raised overflow"); // R2
    AST_UNUSED_QUIET: assert ((op_i <= 5'd16) || (!ovf_o && result_o == '0))
      else $error("unused code produced output"); // R11
  end
endmodule

// File: tb/rv_exec_alu_tb.sv
module rv_exec_alu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic        use_imm, wr_req, ovf, we;
  logic [4:0]  shamt, op;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rv_exec_alu u_dut (
    .a_i (a), .b_i (b), .imm_i (imm), .use_imm_i (use_imm),
    .shamt_i (shamt), .op_i (op), .wr_req_i (wr_req),
    .result_o (res), .ovf_o (ovf), .wr_en_o (we)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [15:0] iv, input logic ui, input logic [4:0] sa,
                       input logic wr);
    @(posedge clk); #1;
    op = o; a = av; b = bv; imm = iv; use_imm = ui; shamt = sa; wr_req = wr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 idle result", res, 32'h0);
    chk("R2 idle ovf", {31'b0, ovf}, 32'h0);
    chk("R3 idle we", {31'b0, we}, 32'h0);
  endtask

  task automatic t_logic;
    drive(5'd4, 32'hABCD1234, 32'hFFFF0000, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R4 and", res, 32'hABCD0000);
    drive(5'd5, 32'hABCD1234, 32'hFFFF0000, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R4 or", res, 32'hFFFF1234);
    drive(5'd6, 32'hABCD1234, 32'hFFFF0000, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R4 xor", res, 32'h54321234);
    drive(5'd7, 32'hABCD1234, 32'hFFFF0000, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R4 nor", res, 32'h0000EDCB);
  endtask

  task automatic t_shift;
    drive(5'd8, 32'h0, 32'hABCD1234, 16'h0, 1'b0, 5'd8, 1'b1);
    chk("R5 sll 8", res, 32'hCD123400);
    drive(5'd10, 32'h0, 32'hABCD1234, 16'h0, 1'b0, 5'd4, 1'b1);
    chk("R7 sra 4", res, 32'hFABCD123);
    drive(5'd9, 32'h0, 32'hABCD1234, 16'h0, 1'b0, 5'd16, 1'b1);
    chk("R5 srl 16", res, 32'h0000ABCD);
    drive(5'd10, 32'h0, 32'h7BCD1234, 16'h0, 1'b0, 5'd4, 1'b1);
    chk("R7 sra positive", res, 32'h07BCD123);
    drive(5'd12, 32'hFFFFFFF0, 32'hABCD1234, 16'h0, 1'b0, 5'd3, 1'b1);
    chk("R6 srlv high bits ignored", res, 32'h0000ABCD);
    drive(5'd13, 32'h0000001F, 32'h80000000, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R6 R7 srav 31", res, 32'hFFFFFFFF);
    drive(5'd11, 32'h00000001, 32'h80000001, 16'h0, 1'b0, 5'd9, 1'b1);
    chk("R6 sllv 1", res, 32'h00000002);
  endtask

  task automatic t_addsub;
    drive(5'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R1 add wrap", res, 32'h80000000);
    chk("R2 add ovf", {31'b0, ovf}, 32'h1);
    chk("R3 add we dropped", {31'b0, we}, 32'h0);
    drive(5'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R1 addu", res, 32'h80000000);
    chk("R2 addu no ovf", {31'b0, ovf}, 32'h0);
    chk("R3 addu we kept", {31'b0, we}, 32'h1);
    drive(5'd2, 32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R1 sub wrap", res, 32'h7FFFFFFF);
    chk("R2 sub ovf", {31'b0, ovf}, 32'h1);
    chk("R3 sub we dropped", {31'b0, we}, 32'h0);
    drive(5'd3, 32'h80000000, 32'h1, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R2 subu no ovf", {31'b0, ovf}, 32'h0);
    drive(5'd2, 32'h00000010, 32'h00000003, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R1 sub plain", res, 32'h0000000D);
    chk("R3 sub plain we", {31'b0, we}, 32'h1);
    drive(5'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0, 5'd0, 1'b0);
    chk("R3 no request", {31'b0, we}, 32'h0);
  endtask

  task automatic t_compare;
    drive(5'd14, 32'h1, 32'hFFFFFFFF, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R8 slt signed", res, 32'h0);
    drive(5'd15, 32'h1, 32'hFFFFFFFF, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R8 sltu unsigned", res, 32'h1);
    drive(5'd14, 32'h80000000, 32'h7FFFFFFF, 16'h0, 1'b0, 5'd0, 1'b1);
    chk("R8 slt extreme", res, 32'h1);
    drive(5'd14, 32'h1, 32'h0, 16'hFFFF, 1'b1, 5'd0, 1'b1);
    chk("R9 slti sign-ext", res, 32'h0);
    drive(5'd15, 32'h1, 32'h0, 16'hFFFF, 1'b1, 5'd0, 1'b1);
    chk("R9 sltiu sign-ext", res, 32'h1);
  endtask

  task automatic t_imm;
    drive(5'd4, 32'hABCD1234, 32'hFFFFFFFF, 16'hFFFF, 1'b1, 5'd0, 1'b1);
    chk("R9 andi zero-ext", res, 32'h00001234);
    drive(5'd0, 32'h5, 32'h0, 16'hFFFF, 1'b1, 5'd0, 1'b1);
    chk("R9 addi sign-ext", res, 32'h4);
    drive(5'd16, 32'h0, 32'h0, 16'hAC51, 1'b0, 5'd0, 1'b1);
    chk("R10 lui", res, 32'hAC510000);
    drive(5'd5, res, 32'h0, 16'h65D9, 1'b1, 5'd0, 1'b1);
    chk("R9 R10 ori builds constant", res, 32'hAC5165D9);
    drive(5'd16, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 1'b1, 5'd7, 1'b1);
    chk("R10 lui use_imm", res, 32'h12340000);
  endtask

  task automatic t_unused;
    drive(5'd31, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 1'b0, 5'd3, 1'b1);
    chk("R11 unused result", res, 32'h0);
    chk("R11 unused ovf", {31'b0, ovf}, 32'h0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    op = 5'd0; a = '0; b = '0; imm = '0; use_imm = 1'b0; shamt = '0; wr_req = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_logic();
    t_shift();
    t_addsub();
    t_compare();
    t_imm();
    t_unused();
    done = 1'b1;
    finish_run();
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end
endmodule